// File: doc/BRIEF.md
# USB Host Transaction Error and Interrupt Tracker

This block works beside the transaction engine of a full-speed USB host controller. It holds the status of the transfer descriptor being worked on: its active flag, its stalled flag, its CRC/time-out flag, a two-bit error budget and an interrupt-on-complete flag. A bit-time turnaround timer runs after each end-of-packet and flags a time-out when no start-of-packet follows within 19 bit times. An external receive checker reports CRC failures. Either kind of error uses up one unit of the descriptor's error budget. When the budget runs out, the descriptor is retired as stalled. A budget loaded as zero means the descriptor may retry without limit.

Each descriptor update goes out as a one-cycle writeback strobe with the new status values. Interrupt conditions from writebacks during a frame wait in a per-frame latch. They reach the status register only at the frame boundary, so software sees a status bit only after the frame's last writeback. The level interrupt is the OR of the status bits that are both set and enabled. It stays high until software clears the bits by writing ones.

Top module: `usb_txn_err_tracker`

## Requirements
- R1: After reset, td_active, td_stalled, td_crc_to, td_cerr, sts_pend, wb_valid, bus_timeout and irq are all zero.
- R2: After eop_det, bus_timeout goes high for exactly one cycle, in the cycle after the clock edge that samples the 19th bit_tick. Fewer ticks produce no time-out.
- R3: Two rules govern a running time-out count. A sop_det stops the count, so no time-out follows until the next eop_det. A new eop_det restarts the count from zero.
- R4: An error (rx_crc_bad or bus_timeout) on an active descriptor with td_cerr of 2 or 3 lowers td_cerr by one and leaves td_active at 1.
- R5: An error on an active descriptor with td_cerr of 1 sets td_cerr to 0, td_active to 0, td_stalled to 1 and td_crc_to to 1.
- R6: A descriptor loaded with td_cerr_init of 0 keeps td_cerr at 0 and td_active at 1 through any number of errors.
- R7: txn_good on an active descriptor clears td_active and leaves td_cerr unchanged, with td_stalled and td_crc_to at 0. An error in the same cycle takes priority.
- R8: Errors and txn_good on an inactive descriptor have no effect: wb_valid stays low and the status is unchanged.
- R9: A retirement sets sts_pend bit 1 (error) only in the cycle after a frame_end pulse. A writeback strobed in the same cycle as frame_end is included in that frame. An error sampled in the same cycle as frame_end falls into the next frame.
- R10: Completion of a descriptor loaded with td_ioc_init=1 sets sts_pend bit 0 at the next frame end. Without the flag, that bit is not set.
- R11: irq equals the OR over bits of sts_pend AND int_en (bit 0 IOC, bit 1 error). A status bit is set whatever its enable value.
- R12: Writing sts_clr clears each sts_pend bit whose sts_clr bit is one, using bit 0 for IOC and bit 1 for error. Other bits are held.
- R13: wb_valid is high for one cycle in the cycle after each clock edge that applies an error or a completion to an active descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per 12 MHz bit time |
| eop_det | input | 1 | End-of-packet seen on the bus; starts the turnaround count |
| sop_det | input | 1 | Start-of-packet seen; stops the turnaround count |
| rx_crc_bad | input | 1 | Receive checker reports a CRC failure |
| txn_good | input | 1 | Transaction finished successfully |
| td_load | input | 1 | Load a new descriptor's status |
| td_cerr_init | input | 2 | Error budget of the loaded descriptor (0 = unlimited) |
| td_ioc_init | input | 1 | Interrupt-on-complete flag of the loaded descriptor |
| frame_end | input | 1 | Frame boundary pulse |
| int_en | input | 2 | Interrupt enables: bit 0 IOC, bit 1 error |
| sts_clr | input | 2 | Write-one-to-clear strobes for sts_pend |
| bus_timeout | output | 1 | Turnaround time-out pulse |
| wb_valid | output | 1 | Descriptor status writeback strobe |
| td_active | output | 1 | Descriptor active flag |
| td_stalled | output | 1 | Descriptor stalled flag |
| td_crc_to | output | 1 | Descriptor CRC/time-out flag |
| td_cerr | output | 2 | Remaining error budget |
| sts_pend | output | 2 | Status bits: bit 0 IOC, bit 1 error |
| irq | output | 1 | Level interrupt |

## Verification
A wrong error budget shows on td_cerr at the first writeback after the error that caused it. It also shows as a retirement that comes one error early or late. A turnaround count that is off by one moves bus_timeout by a whole tick, and the tick-by-tick sweeps see that. A frame latch that passes conditions early, or loses them, shows on sts_pend and irq in the cycle after a frame_end. This holds for every budget, error count and enable combination in the sweep.

// File: rtl/usb_err_pkg.sv
package usb_err_pkg;

    localparam int CERR_W        = 2;
    localparam int STS_W         = 2;
    localparam int STS_IOC       = 0;
    localparam int STS_ERR       = 1;
    localparam int TURN_BITS_DEF = 19;

    typedef struct packed {
        logic              active;
        logic              stalled;
        logic              crc_to;
        logic [CERR_W-1:0] cerr;
        logic              ioc;
    } td_state_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RETRY,
        EV_RETIRE,
        EV_FREE,
        EV_DONE
    } td_ev_t;

    function automatic td_ev_t classify(td_state_t s, logic err, logic ok);
        td_ev_t ev;
        ev = EV_NONE;
        if (s.active) begin
            if (err) begin
                if (s.cerr == '0)
                    ev = EV_FREE;
                else if (s.cerr == CERR_W'(1))
                    ev = EV_RETIRE;
                else
                    ev = EV_RETRY;
            end else if (ok) begin
                ev = EV_DONE;
            end
        end
        return ev;
    endfunction

    function automatic td_state_t apply_ev(td_state_t s, td_ev_t ev);
        td_state_t n;
        n = s;
        case (ev)
            EV_RETRY:  n.cerr = s.cerr - CERR_W'(1);
            EV_RETIRE: begin
                n.cerr    = '0;
                n.active  = 1'b0;
                n.stalled = 1'b1;
                n.crc_to  = 1'b1;
            end
            EV_DONE:   n.active = 1'b0;
            default:   n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/turnaround_timer.sv
module turnaround_timer #(
    parameter int TURN_BITS = usb_err_pkg::TURN_BITS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic eop_det,
    input  logic sop_det,
    output logic bus_timeout
);
    localparam int CNT_W = $clog2(TURN_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_BITS - 1);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            cnt         <= '0;
            bus_timeout <= 1'b0;
        end else begin
            bus_timeout <= 1'b0;
            if (eop_det) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (sop_det) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (armed && bit_tick) begin
                if (cnt == LAST) begin
                    armed       <= 1'b0;
                    cnt         <= '0;
                    bus_timeout <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R2
    to_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_timeout |=> !bus_timeout);

    // R3
    sop_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (sop_det && !eop_det) |=> !bus_timeout);

    // R2
    to_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_timeout) |-> $past(armed));

endmodule

// File: rtl/td_status_engine.sv
module td_status_engine
    import usb_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              td_load,
    input  logic [CERR_W-1:0] cerr_init,
    input  logic              ioc_init,
    input  logic              err_ev,
    input  logic              ok_ev,
    output td_state_t         st,
    output logic              wb_valid,
    output logic              wb_retire,
    output logic              wb_ioc
);
    td_ev_t    ev;
    td_state_t load_st;

    always_comb begin
        ev              = classify(st, err_ev, ok_ev);
        load_st.active  = 1'b1;
        load_st.stalled = 1'b0;
        load_st.crc_to  = 1'b0;
        load_st.cerr    = cerr_init;
        load_st.ioc     = ioc_init;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            wb_valid  <= 1'b0;
            wb_retire <= 1'b0;
            wb_ioc    <= 1'b0;
        end else begin
            wb_valid  <= (ev != EV_NONE) && !td_load;
            wb_retire <= (ev == EV_RETIRE) && !td_load;
            wb_ioc    <= (ev == EV_DONE) && st.ioc && !td_load;
            if (td_load)
                st <= load_st;
            else
                st <= apply_ev(st, ev);
        end
    end

    // R5
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.stalled) |-> (!st.active && st.crc_to && st.cerr == '0));

    // R4
    cerr_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !td_load |=> (st.cerr <= $past(st.cerr)));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.active && !td_load) |=> !wb_valid);

    // R6
    free_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.cerr == '0 && !td_load) |=> !wb_retire);

endmodule

// File: rtl/frame_irq_latch.sv
module frame_irq_latch
    import usb_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_valid,
    input  logic             wb_retire,
    input  logic             wb_ioc,
    input  logic             frame_end,
    input  logic [STS_W-1:0] int_en,
    input  logic [STS_W-1:0] sts_clr,
    output logic [STS_W-1:0] sts_pend,
    output logic             irq
);
    logic [STS_W-1:0] arrive;
    logic [STS_W-1:0] frame_q;

    always_comb begin
        arrive          = '0;
        arrive[STS_ERR] = wb_valid && wb_retire;
        arrive[STS_IOC] = wb_valid && wb_ioc;
        irq             = |(sts_pend & int_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= '0;
            sts_pend <= '0;
        end else if (frame_end) begin
            sts_pend <= (sts_pend & ~sts_clr) | frame_q | arrive;
            frame_q  <= '0;
        end else begin
            sts_pend <= sts_pend & ~sts_clr;
            frame_q  <= frame_q | arrive;
        end
    end

    generate
        for (genvar i = 0; i < STS_W; i++) begin : g_chk
            // R12
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (sts_pend[i] && !sts_clr[i]) |=> sts_pend[i]);
            // R9
            set_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(sts_pend[i]) |-> $past(frame_end));
        end
    endgenerate

endmodule

// File: rtl/usb_txn_err_tracker.sv
module usb_txn_err_tracker
    import usb_err_pkg::*;
#(
    parameter int TURN_BITS = TURN_BITS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             eop_det,
    input  logic             sop_det,
    input  logic             rx_crc_bad,
    input  logic             txn_good,
    input  logic             td_load,
    input  logic [CERR_W-1:0] td_cerr_init,
    input  logic             td_ioc_init,
    input  logic             frame_end,
    input  logic [STS_W-1:0] int_en,
    input  logic [STS_W-1:0] sts_clr,
    output logic             bus_timeout,
    output logic             wb_valid,
    output logic             td_active,
    output logic             td_stalled,
    output logic             td_crc_to,
    output logic [CERR_W-1:0] td_cerr,
    output logic [STS_W-1:0] sts_pend,
    output logic             irq
);
    td_state_t st;
    logic      wb_retire;
    logic      wb_ioc;
    logic      err_ev;

    assign err_ev = rx_crc_bad | bus_timeout;

    turnaround_timer #(.TURN_BITS(TURN_BITS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .eop_det    (eop_det),
        .sop_det    (sop_det),
        .bus_timeout(bus_timeout)
    );

    td_status_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .td_load  (td_load),
        .cerr_init(td_cerr_init),
        .ioc_init (td_ioc_init),
        .err_ev   (err_ev),
        .ok_ev    (txn_good),
        .st       (st),
        .wb_valid (wb_valid),
        .wb_retire(wb_retire),
        .wb_ioc   (wb_ioc)
    );

    frame_irq_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .wb_valid (wb_valid),
        .wb_retire(wb_retire),
        .wb_ioc   (wb_ioc),
        .frame_end(frame_end),
        .int_en   (int_en),
        .sts_clr  (sts_clr),
        .sts_pend (sts_pend),
        .irq      (irq)
    );

    assign td_active  = st.active;
    assign td_stalled = st.stalled;
    assign td_crc_to  = st.crc_to;
    assign td_cerr    = st.cerr;

    // R13
    wb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !td_active) |=> !wb_valid);

endmodule

// File: tb/usb_txn_err_tracker_tb.sv
module usb_txn_err_tracker_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 0, eop_det = 0, sop_det = 0, rx_crc_bad = 0, txn_good = 0;
    logic td_load = 0, td_ioc_init = 0, frame_end = 0;
    logic [1:0] td_cerr_init = 0, int_en = 0, sts_clr = 0;
    logic bus_timeout, wb_valid, td_active, td_stalled, td_crc_to, irq;
    logic [1:0] td_cerr, sts_pend;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    usb_txn_err_tracker u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .eop_det(eop_det),
        .sop_det(sop_det), .rx_crc_bad(rx_crc_bad), .txn_good(txn_good),
        .td_load(td_load), .td_cerr_init(td_cerr_init), .td_ioc_init(td_ioc_init),
        .frame_end(frame_end), .int_en(int_en), .sts_clr(sts_clr),
        .bus_timeout(bus_timeout), .wb_valid(wb_valid), .td_active(td_active),
        .td_stalled(td_stalled), .td_crc_to(td_crc_to), .td_cerr(td_cerr),
        .sts_pend(sts_pend), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        {bit_tick, eop_det, sop_det, rx_crc_bad, txn_good, td_load, frame_end} = '0;
        sts_clr = 2'b00;
    endtask

    task automatic load_td(input logic [1:0] c, input logic ioc);
        td_cerr_init = c; td_ioc_init = ioc; td_load = 1;
        idle();
    endtask

    task automatic crc_err();
        rx_crc_bad = 1;
        idle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1;
            idle();
        end
    endtask

    task automatic timeout_err();
        eop_det = 1;
        idle();
        ticks(19);
        idle();
    endtask

    task automatic end_frame();
        frame_end = 1;
        idle();
    endtask

    task automatic clear(input logic [1:0] m);
        sts_clr = m;
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int to_seen;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 active", td_active, 0);
        chk("R1 stalled", td_stalled, 0);
        chk("R1 crc_to", td_crc_to, 0);
        chk("R1 cerr", td_cerr, 0);
        chk("R1 sts", sts_pend, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wb", wb_valid, 0);
        chk("R1 timeout", bus_timeout, 0);

        // R2 time-out sweep over tick counts
        for (int n = 1; n <= 19; n++) begin
            eop_det = 1;
            idle();
            to_seen = 0;
            for (int i = 0; i < n; i++) begin
                bit_tick = 1;
                idle();
                if (i < n - 1) to_seen += bus_timeout;
            end
            chk("R2 no early timeout", to_seen, 0);
            chk("R2 timeout at tick", bus_timeout, (n == 19) ? 1 : 0);
            sop_det = 1;
            idle();
            chk("R2 single pulse", bus_timeout, 0);
        end

        // R3 sop stops the count
        eop_det = 1; idle();
        ticks(10);
        sop_det = 1; idle();
        to_seen = 0;
        for (int i = 0; i < 30; i++) begin
            bit_tick = 1; idle(); to_seen += bus_timeout;
        end
        chk("R3 sop stops", to_seen, 0);

        // R3 eop restarts from zero
        eop_det = 1; idle();
        ticks(15);
        eop_det = 1; idle();
        to_seen = 0;
        for (int i = 0; i < 18; i++) begin
            bit_tick = 1; idle(); to_seen += bus_timeout;
        end
        chk("R3 restart no timeout at 18", to_seen, 0);
        ticks(1);
        chk("R3 restart timeout at 19", bus_timeout, 1);
        idle();
        chk("R8 inactive timeout no wb", wb_valid, 0);

        // Budget x error count x enable sweep: R4 R5 R6 R7 R8 R10 R11 R12 R13
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 5; k++) begin
                for (int en = 0; en < 4; en++) begin
                    int  exp_cerr;
                    bit  retired;
                    bit  ioc;
                    int  exp_sts;
                    ioc = ((k + en) % 2) == 1;
                    int_en = 2'(en);
                    load_td(2'(c), ioc);
                    exp_cerr = c;
                    retired  = 0;
                    for (int e = 0; e < k; e++) begin
                        if (((e + c + en) % 3) == 0)
                            timeout_err();
                        else
                            crc_err();
                        if (!retired) begin
                            chk("R13 wb after error", wb_valid, 1);
                            if (exp_cerr == 1) begin
                                retired = 1; exp_cerr = 0;
                            end else if (exp_cerr > 1) begin
                                exp_cerr--;
                            end
                        end else begin
                            chk("R8 retired ignores error", wb_valid, 0);
                        end
                    end
                    chk("R4 cerr", td_cerr, exp_cerr);
                    chk("R5 stalled", td_stalled, retired);
                    chk("R5 crc_to", td_crc_to, retired);
                    chk("R6 active", td_active, retired ? 0 : 1);
                    if (!retired) begin
                        txn_good = 1; idle();
                        chk("R13 wb on done", wb_valid, 1);
                        chk("R7 active", td_active, 0);
                        chk("R7 cerr kept", td_cerr, exp_cerr);
                        chk("R7 stalled", td_stalled, 0);
                        chk("R7 crc_to", td_crc_to, 0);
                        crc_err();
                        chk("R8 done ignores error", wb_valid, 0);
                        chk("R8 done cerr", td_cerr, exp_cerr);
                    end
                    idle();
                    chk("R9 not before frame end", sts_pend, 0);
                    end_frame();
                    exp_sts = (retired ? 2 : 0) + ((!retired && ioc) ? 1 : 0);
                    chk("R10 sts after frame", sts_pend, exp_sts);
                    chk("R11 irq", irq, ((exp_sts & en) != 0) ? 1 : 0);
                    clear(2'b10);
                    chk("R12 clear err keeps ioc", sts_pend, exp_sts & 1);
                    clear(2'b01);
                    chk("R12 clear all", sts_pend, 0);
                    chk("R11 irq after clear", irq, 0);
                end
            end
        end

        // R9 writeback in the frame_end cycle is included
        int_en = 2'b10;
        load_td(2'd1, 1'b0);
        rx_crc_bad = 1; idle();
        frame_end = 1; idle();
        chk("R9 same-cycle wb included", sts_pend, 2);
        chk("R11 irq err", irq, 1);
        clear(2'b10);

        // R9 error sampled with frame_end falls into next frame
        load_td(2'd1, 1'b0);
        rx_crc_bad = 1; frame_end = 1; idle();
        idle();
        chk("R9 deferred to next frame", sts_pend, 0);
        end_frame();
        chk("R9 set at next frame", sts_pend, 2);
        clear(2'b10);

        // R7 error wins over success in the same cycle
        load_td(2'd3, 1'b0);
        rx_crc_bad = 1; txn_good = 1; idle();
        chk("R7 error priority active", td_active, 1);
        chk("R7 error priority cerr", td_cerr, 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule